// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Buffer

This block lets a bus master read up to four serial flash devices as if they were ordinary memory. Each read address is matched against four programmable upper-bound registers. Each register closes a window, and each window belongs to one device. The buffer keeps one contiguous run of bytes from one device.

A read that falls inside the buffered run is answered from local storage. A read that falls outside it discards the buffer and starts a burst read on the flash sequencer at the missed word. The read completes once its own four bytes have arrived. The sequence index and the burst length both come from configuration inputs. The burst length is given in eight-byte units.

Software invalidates the buffer after a program or erase. It does this by holding the bus-side and flash-side soft-reset controls high together for a minimum number of cycles.

Top module: `flash_rdbuf`

## Requirements
- R1: The device index is the lowest i (0 to 3) for which the word address is below `cfg_top[i]`. Window 0 starts at address 0. The `cfg_top` values are programmed in ascending order. `cs_idx` reports the device of the buffered run.
- R2: A read at or above `cfg_top[3]` completes one cycle after it is accepted, with `rd_data` equal to zero and no sequence launched.
- R3: A read that is not a hit, received while no refill runs, empties the buffer. It raises `seq_start` for exactly one cycle, with `seq_addr` equal to the read address with bits 1:0 cleared, `seq_id` equal to `cfg_seq_id`, and `cs_idx` equal to the device from R1.
- R4: `seq_len` equals `cfg_fill_units` × 8 bytes. A value of 0 gives 8 bytes. A value above BUF_BYTES/8 gives BUF_BYTES bytes.
- R5: A read is a hit when the buffer is live, the device matches, and the word address lies in [base, base + length). A hit completes one cycle after acceptance and launches no sequence. The first word past the run is a miss.
- R6: `rd_data` is little-endian. Bits 7:0 hold the byte at the word address and bits 31:24 the byte at address + 3. Address bits 1:0 are ignored.
- R7: `busy` is low after reset. It is high from the cycle in which `seq_start` is high until the cycle after the last burst byte is captured.
- R8: A read into the window of a refill in progress completes only after byte (offset + 3) of that refill has been captured. A read outside that window waits until the refill ends, and then launches a new one.
- R9: `rd_ready` is low after reset and is a single-cycle pulse. `rd_req` must be held until `rd_ready` is seen. A request present in the `rd_ready` cycle is ignored.
- R10: Holding `srst_bus` and `srst_flash` high together for SRST_HOLD consecutive cycles (default 3) empties the buffer, so the next read is a miss. A shorter overlap leaves the contents intact.
- R11: Either soft-reset input high on its own, for any length of time, leaves the buffer contents intact.
- R12: While both soft-reset inputs are high, no read completes and no sequence is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_top | input | 4×ADDR_W | Upper bound (exclusive) of each device window |
| cfg_seq_id | input | 4 | Sequence index used for refills |
| cfg_fill_units | input | 8 | Refill length in 8-byte units |
| srst_bus | input | 1 | Bus-side soft reset |
| srst_flash | input | 1 | Flash-side soft reset |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | ADDR_W | Read byte address |
| rd_ready | output | 1 | Read complete pulse |
| rd_data | output | 32 | Read data, valid with `rd_ready` |
| seq_start | output | 1 | One-cycle launch of a refill sequence |
| seq_id | output | 4 | Sequence index of the launch |
| seq_addr | output | ADDR_W | Start address of the refill |
| seq_len | output | LEN_W | Refill length in bytes |
| seq_valid | input | 1 | Sequencer byte strobe |
| seq_data | input | 8 | Sequencer byte |
| cs_idx | output | 2 | Device of the buffered run |
| busy | output | 1 | Refill in progress |

## Verification
The assertions assume three things about the environment. The master holds its request and address steady until `rd_ready`. The window bounds rise with the index. The sequencer delivers exactly `seq_len` bytes per launch and none otherwise.

The bench sequencer model streams exactly the requested count, with random idle gaps, from a flash content function. The read task keeps the address fixed until completion. The bounds are programmed once in ascending order.

Soft reset is applied only while no refill is running, because the flash-side reset is taken to quiet the sequencer. The one exception is the stall check, where a request is already waiting.

// File: rtl/frb_pkg.sv
package frb_pkg;

    localparam int DEV_NUM    = 4;
    localparam int CS_W       = 2;
    localparam int FILL_UNIT  = 8;
    localparam int WORD_BYTES = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic            in_map;
        logic [CS_W-1:0] cs;
    } dev_sel_t;

    // Refill byte count: zero units means one unit, clipped to the buffer size
    function automatic logic [15:0] fill_bytes(input logic [7:0] units,
                                               input int unsigned cap);
        logic [15:0] b;
        b = (units == 8'd0) ? 16'(FILL_UNIT) : 16'(units) * 16'(FILL_UNIT);
        if (b > 16'(cap))
            b = 16'(cap);
        return b;
    endfunction

endpackage

// File: rtl/frb_region_dec.sv
module frb_region_dec
    import frb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DEV_NUM-1:0][ADDR_W-1:0] tops,
    output dev_sel_t                       sel
);

    logic [DEV_NUM-1:0] below;

    for (genvar g = 0; g < DEV_NUM; g++) begin : g_cmp
        assign below[g] = addr < tops[g];
    end

    // lowest window whose top lies above the address wins
    always_comb begin
        sel.in_map = 1'b0;
        sel.cs     = '0;
        for (int i = DEV_NUM - 1; i >= 0; i--) begin
            if (below[i]) begin
                sel.in_map = 1'b1;
                sel.cs     = CS_W'(i);
            end
        end
    end

endmodule

// File: rtl/frb_byte_store.sv
module frb_byte_store
    import frb_pkg::*;
#(
    parameter  int BUF_BYTES = 1024,
    localparam int IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_byte,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [8*WORD_BYTES-1:0] rd_word
);

    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_byte;
    end

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign rd_word[8*g +: 8] = mem[rd_idx + IDX_W'(g)];
    end

endmodule

// File: rtl/frb_fill_ctrl.sv
module frb_fill_ctrl
    import frb_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int BUF_BYTES = 1024,
    parameter  int SRST_HOLD = 3,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1,
    localparam int IDX_W     = $clog2(BUF_BYTES),
    localparam int SR_W      = $clog2(SRST_HOLD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr_al,
    input  dev_sel_t          dsel,
    input  logic              hold_off,
    input  logic [3:0]        cfg_seq_id,
    input  logic [7:0]        cfg_fill_units,
    input  logic              srst_both,
    input  logic              seq_valid,
    output logic              serve_hit,
    output logic              serve_void,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_en,
    output logic              seq_start,
    output logic [3:0]        seq_id,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [LEN_W-1:0]  seq_len,
    output logic [CS_W-1:0]   cs_idx,
    output logic              busy
);

    fill_state_e       state;
    logic              tag_live;
    logic [ADDR_W-1:0] tag_base;
    logic [CS_W-1:0]   tag_cs;
    logic [LEN_W-1:0]  fill_len;
    logic [LEN_W-1:0]  land_cnt;
    logic [SR_W-1:0]   srst_cnt;

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic              landed;
    logic              go;
    logic              launch;
    logic              srst_fire;

    always_comb begin
        off        = addr_al - tag_base;
        in_win     = tag_live && (tag_cs == dsel.cs) && (addr_al >= tag_base)
                     && (off < ADDR_W'(fill_len));
        landed     = (off + ADDR_W'(WORD_BYTES)) <= ADDR_W'(land_cnt);
        go         = req && !hold_off && !srst_both;
        serve_hit  = go && dsel.in_map && in_win && landed;
        serve_void = go && !dsel.in_map;
        launch     = go && dsel.in_map && !in_win && (state == ST_IDLE);
        srst_fire  = srst_both && (srst_cnt == SR_W'(SRST_HOLD - 1));
    end

    assign rd_idx = off[IDX_W-1:0];
    assign wr_idx = land_cnt[IDX_W-1:0];
    assign wr_en  = (state == ST_FILL) && seq_valid;
    assign busy   = (state == ST_FILL);
    assign cs_idx = tag_cs;

    // consecutive cycles with both soft-reset controls high
    always_ff @(posedge clk) begin
        if (rst)
            srst_cnt <= '0;
        else if (!srst_both)
            srst_cnt <= '0;
        else if (srst_cnt != SR_W'(SRST_HOLD))
            srst_cnt <= srst_cnt + SR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tag_live  <= 1'b0;
            tag_base  <= '0;
            tag_cs    <= '0;
            fill_len  <= '0;
            land_cnt  <= '0;
            seq_start <= 1'b0;
            seq_id    <= '0;
            seq_addr  <= '0;
            seq_len   <= '0;
        end else begin
            seq_start <= 1'b0;
            if (srst_fire) begin
                state    <= ST_IDLE;
                tag_live <= 1'b0;
                land_cnt <= '0;
            end else if (launch) begin
                state     <= ST_FILL;
                tag_live  <= 1'b1;
                tag_base  <= addr_al;
                tag_cs    <= dsel.cs;
                fill_len  <= LEN_W'(fill_bytes(cfg_fill_units, BUF_BYTES));
                land_cnt  <= '0;
                seq_start <= 1'b1;
                seq_id    <= cfg_seq_id;
                seq_addr  <= addr_al;
                seq_len   <= LEN_W'(fill_bytes(cfg_fill_units, BUF_BYTES));
            end else if (wr_en) begin
                land_cnt <= land_cnt + LEN_W'(1);
                if (land_cnt + LEN_W'(1) == fill_len)
                    state <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/flash_rdbuf.sv
module flash_rdbuf
    import frb_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int BUF_BYTES = 1024,
    parameter  int SRST_HOLD = 3,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1,
    localparam int IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DEV_NUM-1:0][ADDR_W-1:0] cfg_top,
    input  logic [3:0]                 cfg_seq_id,
    input  logic [7:0]                 cfg_fill_units,
    input  logic                       srst_bus,
    input  logic                       srst_flash,
    input  logic                       rd_req,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic                       rd_ready,
    output logic [31:0]                rd_data,
    output logic                       seq_start,
    output logic [3:0]                 seq_id,
    output logic [ADDR_W-1:0]          seq_addr,
    output logic [LEN_W-1:0]           seq_len,
    input  logic                       seq_valid,
    input  logic [7:0]                 seq_data,
    output logic [CS_W-1:0]            cs_idx,
    output logic                       busy
);

    logic [ADDR_W-1:0] addr_al;
    dev_sel_t          dsel;
    logic              serve_hit;
    logic              serve_void;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_en;
    logic [31:0]       buf_word;

    assign addr_al = rd_addr & ~ADDR_W'(WORD_BYTES - 1);

    frb_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr_al),
        .tops (cfg_top),
        .sel  (dsel)
    );

    frb_fill_ctrl #(
        .ADDR_W    (ADDR_W),
        .BUF_BYTES (BUF_BYTES),
        .SRST_HOLD (SRST_HOLD)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req            (rd_req),
        .addr_al        (addr_al),
        .dsel           (dsel),
        .hold_off       (rd_ready),
        .cfg_seq_id     (cfg_seq_id),
        .cfg_fill_units (cfg_fill_units),
        .srst_both      (srst_bus && srst_flash),
        .seq_valid      (seq_valid),
        .serve_hit      (serve_hit),
        .serve_void     (serve_void),
        .rd_idx         (rd_idx),
        .wr_idx         (wr_idx),
        .wr_en          (wr_en),
        .seq_start      (seq_start),
        .seq_id         (seq_id),
        .seq_addr       (seq_addr),
        .seq_len        (seq_len),
        .cs_idx         (cs_idx),
        .busy           (busy)
    );

    frb_byte_store #(.BUF_BYTES(BUF_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (seq_data),
        .rd_idx  (rd_idx),
        .rd_word (buf_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ready <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_ready <= serve_hit || serve_void;
            if (serve_hit)
                rd_data <= buf_word;
            else if (serve_void)
                rd_data <= '0;
        end
    end

endmodule

// File: rtl/flash_rdbuf_chk.sv
module flash_rdbuf_chk
    import frb_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int BUF_BYTES = 1024,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1
) (
    input logic                           clk,
    input logic                           rst,
    input logic [DEV_NUM-1:0][ADDR_W-1:0] cfg_top,
    input logic                           srst_bus,
    input logic                           srst_flash,
    input logic                           rd_req,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic                           rd_ready,
    input logic [31:0]                    rd_data,
    input logic                           seq_start,
    input logic [ADDR_W-1:0]              seq_addr,
    input logic [LEN_W-1:0]               seq_len,
    input logic [CS_W-1:0]                cs_idx,
    input logic                           busy
);

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> (seq_addr % ADDR_W'(WORD_BYTES)) == '0);  // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !seq_start);  // R3

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> (seq_len >= LEN_W'(FILL_UNIT)) && (seq_len <= LEN_W'(BUF_BYTES))
                      && ((seq_len % LEN_W'(FILL_UNIT)) == '0));  // R4

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> busy);  // R7

    AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cs_idx));  // R1

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_ready |=> !rd_ready);  // R9

    AST_VOID_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && $past(rd_req) && ($past(rd_addr) >= $past(cfg_top[DEV_NUM-1])))
        |-> rd_data == '0);  // R2

    AST_SRST_STALL: assert property (@(posedge clk) disable iff (rst)
        $past(srst_bus && srst_flash) |-> (!rd_ready && !seq_start));  // R12

endmodule

bind flash_rdbuf flash_rdbuf_chk #(
    .ADDR_W    (ADDR_W),
    .BUF_BYTES (BUF_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_top    (cfg_top),
    .srst_bus   (srst_bus),
    .srst_flash (srst_flash),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .seq_start  (seq_start),
    .seq_addr   (seq_addr),
    .seq_len    (seq_len),
    .cs_idx     (cs_idx),
    .busy       (busy)
);

// File: tb/flash_rdbuf_test.sv
module flash_rdbuf_test;

    localparam int ADDR_W = 32;
    localparam int BUFB   = 1024;
    localparam int LEN_W  = $clog2(BUFB) + 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [3:0][31:0]      cfg_top;
    logic [3:0]            cfg_seq_id = 4'd5;
    logic [7:0]            cfg_fill_units = 8'd4;
    logic                  srst_bus = 1'b0;
    logic                  srst_flash = 1'b0;
    logic                  rd_req = 1'b0;
    logic [31:0]           rd_addr = '0;
    logic                  rd_ready;
    logic [31:0]           rd_data;
    logic                  seq_start;
    logic [3:0]            seq_id;
    logic [31:0]           seq_addr;
    logic [LEN_W-1:0]      seq_len;
    logic                  seq_valid = 1'b0;
    logic [7:0]            seq_data = '0;
    logic [1:0]            cs_idx;
    logic                  busy;

    int n_chk = 0;
    int n_fail = 0;
    int start_cnt = 0;
    int overlap_err = 0;
    int busy_err = 0;
    int gap_pct = 0;
    int sq_rem = 0;
    int sq_pos = 0;
    logic [31:0] sq_addr = '0;
    logic [1:0]  sq_cs = '0;
    logic [31:0] last_addr = '0;
    int          last_len = 0;
    logic [3:0]  last_id = '0;
    logic [1:0]  last_cs = '0;

    always #10 clk = ~clk;

    flash_rdbuf #(.ADDR_W(ADDR_W), .BUF_BYTES(BUFB), .SRST_HOLD(3)) uut (
        .clk(clk), .rst(rst), .cfg_top(cfg_top), .cfg_seq_id(cfg_seq_id),
        .cfg_fill_units(cfg_fill_units), .srst_bus(srst_bus), .srst_flash(srst_flash),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .seq_start(seq_start), .seq_id(seq_id), .seq_addr(seq_addr), .seq_len(seq_len),
        .seq_valid(seq_valid), .seq_data(seq_data), .cs_idx(cs_idx), .busy(busy)
    );

    function automatic logic [7:0] fbyte(input logic [1:0] cs, input logic [31:0] a);
        return (a[7:0] ^ {a[11:8], a[15:12]}) + {cs, 6'h13};
    endfunction

    function automatic logic [1:0] exp_cs(input logic [31:0] a);
        if (a < cfg_top[0]) return 2'd0;
        if (a < cfg_top[1]) return 2'd1;
        if (a < cfg_top[2]) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] al;
        logic [1:0]  c;
        al = a & ~32'd3;
        c  = exp_cs(al);
        return {fbyte(c, al + 3), fbyte(c, al + 2), fbyte(c, al + 1), fbyte(c, al)};
    endfunction

    function automatic int exp_len(input logic [7:0] u);
        int b;
        b = (u == 0) ? 8 : int'(u) * 8;
        return (b > BUFB) ? BUFB : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // flash sequencer model: drives bytes shortly after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (rst) begin
            sq_rem    = 0;
            seq_valid = 1'b0;
        end else begin
            if (sq_rem > 0 && int'($urandom % 100) >= gap_pct) begin
                seq_valid = 1'b1;
                seq_data  = fbyte(sq_cs, sq_addr + 32'(sq_pos));
                sq_pos++;
                sq_rem--;
            end else begin
                seq_valid = 1'b0;
            end
            if (seq_start) begin
                if (sq_rem != 0) overlap_err++;
                start_cnt++;
                last_addr = seq_addr;
                last_len  = int'(seq_len);
                last_id   = seq_id;
                last_cs   = cs_idx;
                sq_addr   = seq_addr;
                sq_cs     = cs_idx;
                sq_rem    = int'(seq_len);
                sq_pos    = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && (busy !== ((sq_rem > 0) || seq_valid))) busy_err++;
    end

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int captured);
        int n;
        n = 0;
        rd_addr = a;
        rd_req  = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!rd_ready && n < 5000);
        captured = sq_pos - (seq_valid ? 1 : 0);
        d = rd_data;
        rd_req = 1'b0;
        if (n >= 5000) chk(1'b0, "R9 read timeout", a, 32'd0);
    endtask

    task automatic rd_chk(input logic [31:0] a, input bit exp_miss, input string tag);
        logic [31:0] d;
        int cap;
        int s0;
        s0 = start_cnt;
        do_read(a, d, cap);
        chk(d === exp_word(a), {tag, " R6 data"}, d, exp_word(a));
        chk((start_cnt - s0) == (exp_miss ? 1 : 0), {tag, " R5 launch count"},
            32'(start_cnt - s0), exp_miss ? 32'd1 : 32'd0);
    endtask

    task automatic hold_srst(input int n, input bit b, input bit f);
        srst_bus   = b;
        srst_flash = f;
        repeat (n) @(negedge clk);
        srst_bus   = 1'b0;
        srst_flash = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while ((busy || sq_rem > 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cap;
        int s0;
        logic [31:0] t_base;
        int t_len;
        logic [1:0] t_cs;
        bit t_live;

        void'($urandom(32'd4711));
        cfg_top[0] = 32'h0000_1000;
        cfg_top[1] = 32'h0000_3000;
        cfg_top[2] = 32'h0000_3800;
        cfg_top[3] = 32'h0000_8000;
        repeat (4) @(negedge clk);
        chk(rd_ready === 1'b0, "R9 reset ready", 32'(rd_ready), 32'd0);
        chk(busy === 1'b0, "R7 reset busy", 32'(busy), 32'd0);
        chk(seq_start === 1'b0, "R3 reset start", 32'(seq_start), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // first miss: low address bits ignored
        rd_chk(32'h0000_0106, 1'b1, "R3 first miss");
        chk(last_addr == 32'h104, "R3 seq_addr", last_addr, 32'h104);
        chk(last_id == 4'd5, "R3 seq_id", 32'(last_id), 32'd5);
        chk(last_len == 32, "R4 seq_len", 32'(last_len), 32'd32);
        chk(last_cs == 2'd0, "R1 cs dev0", 32'(last_cs), 32'd0);
        wait_idle();
        rd_chk(32'h0000_0110, 1'b0, "R5 hit mid");
        rd_chk(32'h0000_0120, 1'b0, "R5 hit last word");
        rd_chk(32'h0000_0124, 1'b1, "R5 first word past run");
        wait_idle();

        // window boundaries
        rd_chk(32'h0000_0FFC, 1'b1, "R1 top0-4");
        chk(last_cs == 2'd0, "R1 cs below top0", 32'(last_cs), 32'd0);
        wait_idle();
        rd_chk(32'h0000_1000, 1'b1, "R1 at top0");
        chk(last_cs == 2'd1, "R1 cs at top0", 32'(last_cs), 32'd1);
        wait_idle();
        rd_chk(32'h0000_3000, 1'b1, "R1 at top1");
        chk(last_cs == 2'd2, "R1 cs at top1", 32'(last_cs), 32'd2);
        wait_idle();
        rd_chk(32'h0000_7FFC, 1'b1, "R1 below top3");
        chk(last_cs == 2'd3, "R1 cs dev3", 32'(last_cs), 32'd3);
        wait_idle();

        // unmapped reads
        s0 = start_cnt;
        do_read(32'h0000_8000, d, cap);
        chk(d == 32'd0, "R2 data at top3", d, 32'd0);
        do_read(32'hFFFF_0000, d, cap);
        chk(d == 32'd0, "R2 data high", d, 32'd0);
        chk(start_cnt == s0, "R2 no launch", 32'(start_cnt - s0), 32'd0);

        // length corners
        cfg_fill_units = 8'd0;
        rd_chk(32'h0000_0400, 1'b1, "R4 zero units");
        chk(last_len == 8, "R4 zero units len", 32'(last_len), 32'd8);
        wait_idle();
        rd_chk(32'h0000_0404, 1'b0, "R4 8-byte run last word");
        rd_chk(32'h0000_0408, 1'b1, "R4 8-byte run past");
        wait_idle();
        cfg_fill_units = 8'd200;
        rd_chk(32'h0000_4000, 1'b1, "R4 clipped");
        chk(last_len == BUFB, "R4 clipped len", 32'(last_len), 32'(BUFB));
        wait_idle();
        rd_chk(32'h0000_43FC, 1'b0, "R4 clipped last word");

        // read during refill, inside the window
        cfg_fill_units = 8'd16;
        gap_pct = 50;
        rd_chk(32'h0000_1800, 1'b1, "R8 launch");
        do_read(32'h0000_1840, d, cap);
        chk(cap >= 68, "R8 landed before ready", 32'(cap), 32'd68);
        chk(d == exp_word(32'h1840), "R8 data", d, exp_word(32'h1840));
        wait_idle();
        // outside the window during refill
        rd_chk(32'h0000_2000, 1'b1, "R8 launch b");
        s0 = start_cnt;
        do_read(32'h0000_2400, d, cap);
        chk(start_cnt == s0 + 1, "R8 later miss launches", 32'(start_cnt - s0), 32'd1);
        chk(overlap_err == 0, "R8 no launch during refill", 32'(overlap_err), 32'd0);
        chk(d == exp_word(32'h2400), "R8 data b", d, exp_word(32'h2400));
        wait_idle();
        gap_pct = 0;

        // soft reset
        cfg_fill_units = 8'd4;
        rd_chk(32'h0000_0200, 1'b1, "R10 fill");
        wait_idle();
        hold_srst(2, 1'b1, 1'b1);
        rd_chk(32'h0000_0204, 1'b0, "R10 short overlap keeps");
        hold_srst(10, 1'b1, 1'b0);
        rd_chk(32'h0000_0208, 1'b0, "R11 bus only keeps");
        hold_srst(10, 1'b0, 1'b1);
        rd_chk(32'h0000_020C, 1'b0, "R11 flash only keeps");
        hold_srst(3, 1'b1, 1'b1);
        rd_chk(32'h0000_0200, 1'b1, "R10 invalidated");
        wait_idle();

        // stall while both held with a request waiting
        begin
            int bad;
            bad = 0;
            s0 = start_cnt;
            srst_bus = 1'b1;
            srst_flash = 1'b1;
            rd_addr = 32'h0000_0210;
            rd_req = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (rd_ready || seq_start) bad++;
            end
            chk(bad == 0 && start_cnt == s0, "R12 stall", 32'(bad), 32'd0);
            srst_bus = 1'b0;
            srst_flash = 1'b0;
            begin
                int n;
                n = 0;
                do begin
                    @(negedge clk);
                    n++;
                end while (!rd_ready && n < 5000);
            end
            d = rd_data;
            rd_req = 1'b0;
            chk(d == exp_word(32'h210), "R12 completes after release", d, exp_word(32'h210));
            chk(start_cnt == s0 + 1, "R10 miss after long overlap", 32'(start_cnt - s0), 32'd1);
        end
        wait_idle();
        hold_srst(3, 1'b1, 1'b1);

        // random traffic against a bench model of the buffered run
        t_live = 1'b0;
        t_base = '0;
        t_len = 0;
        t_cs = '0;
        for (int it = 0; it < 150; it++) begin
            logic [31:0] a;
            logic [31:0] al;
            bit miss;
            bit inmap;
            int r;
            case ($urandom % 5)
                0: cfg_fill_units = 8'd0;
                1: cfg_fill_units = 8'd1;
                2: cfg_fill_units = 8'd2;
                3: cfg_fill_units = 8'd4;
                default: cfg_fill_units = 8'd16;
            endcase
            gap_pct = int'($urandom % 60);
            r = int'($urandom % 4);
            if (r == 0)
                a = 32'h8000 + ($urandom % 32'h1000);
            else if (r == 3 || !t_live)
                a = $urandom % 32'h8000;
            else
                a = t_base + ($urandom % 32'(2 * t_len + 8));
            al = a & ~32'd3;
            inmap = al < cfg_top[3];
            miss = inmap && !(t_live && exp_cs(al) == t_cs && al >= t_base
                              && (al - t_base) < 32'(t_len));
            if (inmap) begin
                rd_chk(a, miss, "R5 random");
            end else begin
                s0 = start_cnt;
                do_read(a, d, cap);
                chk(d == 32'd0 && start_cnt == s0, "R2 random unmapped", d, 32'd0);
            end
            if (miss) begin
                t_live = 1'b1;
                t_base = al;
                t_len  = exp_len(cfg_fill_units);
                t_cs   = exp_cs(al);
            end
        end
        wait_idle();
        chk(overlap_err == 0, "R8 no overlapping launches", 32'(overlap_err), 32'd0);
        chk(busy_err == 0, "R7 busy tracks refill", 32'(busy_err), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule